// File: doc/BRIEF.md
# Static Memory Turnaround Gap Sequencer

This block sits in front of the transaction launcher of an external static memory controller that drives four chip-select banks. Each request arrives on a valid/ready handshake and carries a bank number, a read/write flag and a synchronous/asynchronous flag. The block keeps a record of the last transaction it launched. From that record and the waiting request it works out how many idle controller-clock cycles must pass before the new transaction may start. When the gap has passed it accepts the request and raises a one-cycle start strobe.

The gap is not one fixed delay. An asynchronous write is followed by a programmable gap of (turn + 1) cycles. Back-to-back asynchronous writes to one bank run with no gap, unless multiplexed address/data mode or extended access mode D is active. A synchronous write is followed by a fixed gap of 2 or 3 cycles, chosen by the next transaction's type and by its bank. A read, or a block with no transaction since reset, imposes no gap. The 4-bit turn value lives in a small register that resets to its maximum. The value is sampled when a gap starts, so a write to the register during a gap does not change the gap already running.

Top module: `turnaround_gap_seq`

## Requirements
- R1: The turn register resets to 15. A cycle with `cfg_wr` high loads `cfg_turn` into it at the next clock edge.
- R2: When no transaction has started since reset, or the last started transaction was a read, a valid request is accepted in the same cycle it is presented (`req_ready` high, gap of zero).
- R3: After an asynchronous write (`req_write`=1, `req_sync`=0), any following transaction waits turn+1 cycles, except in the case that R4 exempts. The turn value used is the register value in the first cycle the request is presented.
- R4: An asynchronous write that follows an asynchronous write to the same bank starts with no gap. This exemption does not apply when `cfg_muxed`=1, or when `cfg_ext_en`=1 and `cfg_acc_mode`=3 (mode D). In those cases the turn+1 gap applies.
- R5: After a synchronous write, any asynchronous read or write waits exactly 2 cycles, whatever the turn value.
- R6: After a synchronous write, a synchronous write to the same bank waits 2 cycles and a synchronous write to a different bank waits 3 cycles.
- R7: After a synchronous write, a synchronous read to any bank waits 3 cycles.
- R8: The gap is counted from the first cycle a request is presented. `req_ready` stays low for exactly the gap's number of cycles and then goes high. `xfer_start` pulses only in the cycle a request is accepted, and the accepted request becomes the new previous-transaction record.
- R9: A write to the turn register while a gap is being counted does not lengthen or shorten that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the turn register |
| cfg_turn | input | 4 | New turn value |
| cfg_muxed | input | 1 | Multiplexed address/data mode active |
| cfg_ext_en | input | 1 | Extended access-mode timing enabled |
| cfg_acc_mode | input | 2 | Access mode; 3 selects mode D when extended timing is enabled |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_bank | input | 2 | Target bank of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous, 0 = asynchronous |
| xfer_start | output | 1 | One-cycle strobe that launches the accepted transaction |

## Verification
The hardest case to reach is a write to the turn register that lands in the middle of a running gap. The register has to change while the request is held and `req_ready` is low, and the effect only shows as a gap length that did not change. The bench holds a request behind a 16-cycle gap, writes turn = 0 three cycles into it, and checks that the wait still lasts 16 cycles. The random stream also reshuffles the mode inputs and the turn value between transactions, so each of the fixed-gap and exempt pairs is met under several settings.

// File: rtl/tgap_pkg.sv
// Package: shared transaction kinds and mode codes for the turnaround
// gap sequencer. Assumes a kind is fully described by its direction
// and its timing type.
package tgap_pkg;

    typedef enum logic [1:0] {
        TK_ASYNC_RD = 2'b00,
        TK_ASYNC_WR = 2'b01,
        TK_SYNC_RD  = 2'b10,
        TK_SYNC_WR  = 2'b11
    } tgap_kind_t;

    localparam logic [1:0] TG_ACC_MODE_D = 2'd3;

    // Build a kind from the request flags.
    function automatic tgap_kind_t tgap_kind(input logic is_write, input logic is_sync);
        return tgap_kind_t'({is_sync, is_write});
    endfunction

endpackage

// File: rtl/tgap_cfg.sv
// Module: holds the programmable turn value. Resets to all ones, loads
// on a write strobe. Assumes the writer keeps the data stable in the
// strobe cycle.
module tgap_cfg #(
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [TURN_W-1:0] cfg_wdata,
    output logic [TURN_W-1:0] turn_q
);

    localparam logic [TURN_W-1:0] TURN_RST = '1;

    // Turn register: reset to maximum, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= TURN_RST;
        end else if (cfg_wr) begin
            turn_q <= cfg_wdata;
        end
    end

    AST_TURN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (turn_q == TURN_RST)); // R1
    AST_TURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (turn_q == $past(cfg_wdata))); // R1

endmodule

// File: rtl/tgap_history.sv
// Module: record of the last launched transaction (bank and kind) and
// whether any transaction has launched since reset. Updated only on
// the start strobe.
module tgap_history
    import tgap_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BANK_W-1:0] bank,
    input  tgap_kind_t        kind,
    output logic              prev_valid,
    output logic [BANK_W-1:0] prev_bank,
    output tgap_kind_t        prev_kind
);

    // Capture the launched transaction's attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_bank  <= '0;
            prev_kind  <= TK_ASYNC_RD;
        end else if (start) begin
            prev_valid <= 1'b1;
            prev_bank  <= bank;
            prev_kind  <= kind;
        end
    end

    AST_HIST_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (prev_valid && prev_bank == $past(bank) && prev_kind == $past(kind))); // R8
    AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(prev_bank) && $stable(prev_kind))); // R8

endmodule

// File: rtl/tgap_rule.sv
// Module: combinational gap selection from the previous and the next
// transaction. Produces 0, turn+1, or one of two fixed gaps. Assumes
// FIX_NEAR and FIX_FAR fit in GAP_W bits.
module tgap_rule
    import tgap_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int TURN_W   = 4,
    parameter int FIX_NEAR = 2,
    parameter int FIX_FAR  = 3
) (
    input  logic              prev_valid,
    input  logic [BANK_W-1:0] prev_bank,
    input  tgap_kind_t        prev_kind,
    input  logic [BANK_W-1:0] next_bank,
    input  tgap_kind_t        next_kind,
    input  logic [TURN_W-1:0] turn,
    input  logic              muxed,
    input  logic              ext_en,
    input  logic [1:0]        acc_mode,
    output logic [TURN_W:0]   gap
);

    localparam int GAP_W = TURN_W + 1;

    logic same_bank;
    logic strict_mode;
    logic [GAP_W-1:0] prog_gap;

    // Pair qualifiers used by the selection below.
    always_comb begin
        same_bank   = (prev_bank == next_bank);
        strict_mode = muxed || (ext_en && (acc_mode == TG_ACC_MODE_D));
        prog_gap    = GAP_W'(turn) + GAP_W'(1);
    end

    // Gap selection by previous kind, then next kind and bank.
    always_comb begin
        gap = '0;
        if (prev_valid) begin
            case (prev_kind)
                TK_ASYNC_WR: begin
                    if (next_kind == TK_ASYNC_WR && same_bank && !strict_mode) begin
                        gap = '0;
                    end else begin
                        gap = prog_gap;
                    end
                end
                TK_SYNC_WR: begin
                    if (next_kind == TK_ASYNC_RD || next_kind == TK_ASYNC_WR) begin
                        gap = GAP_W'(FIX_NEAR);
                    end else if (next_kind == TK_SYNC_WR && same_bank) begin
                        gap = GAP_W'(FIX_NEAR);
                    end else begin
                        gap = GAP_W'(FIX_FAR);
                    end
                end
                default: gap = '0;
            endcase
        end
    end

endmodule

// File: rtl/tgap_timer.sv
// Module: gap down-counter with a "gap served" flag. On the first
// cycle a request waits, it loads gap-1 and marks the gap as served.
// Ready returns when the count reaches zero. Assumes the requester
// holds the request stable until it is accepted.
module tgap_timer #(
    parameter int GAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [GAP_W-1:0] gap,
    input  logic             start,
    output logic             ready
);

    localparam int CNT_W = GAP_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic             paid_q;
    logic             load;

    // Ready and load decode.
    always_comb begin
        ready = (cnt_q == '0) && ((gap == '0) || paid_q);
        load  = req_valid && !ready && (cnt_q == '0) && !paid_q;
    end

    // Counter and served flag: load on a new wait, count down, clear on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            paid_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= CNT_W'(gap - GAP_W'(1));
            paid_q <= 1'b1;
        end else begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (start) begin
                paid_q <= 1'b0;
            end
        end
    end

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
    AST_START_CLEARS_PAID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !paid_q); // R8

endmodule

// File: rtl/turnaround_gap_seq.sv
// Module: top of the turnaround gap sequencer. Joins the turn register,
// the history record, the gap rule and the timer. A request is accepted
// when the timer reports ready, and the acceptance is the start strobe.
module turnaround_gap_seq
    import tgap_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int TURN_W   = 4,
    parameter int FIX_NEAR = 2,
    parameter int FIX_FAR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [TURN_W-1:0] cfg_turn,
    input  logic              cfg_muxed,
    input  logic              cfg_ext_en,
    input  logic [1:0]        cfg_acc_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_write,
    input  logic              req_sync,
    output logic              xfer_start
);

    localparam int GAP_W = TURN_W + 1;

    logic [TURN_W-1:0] turn_q;
    logic              prev_valid;
    logic [BANK_W-1:0] prev_bank;
    tgap_kind_t        prev_kind;
    tgap_kind_t        next_kind;
    logic [GAP_W-1:0]  gap_now;

    // Request kind and launch strobe.
    always_comb begin
        next_kind  = tgap_kind(req_write, req_sync);
        xfer_start = req_valid && req_ready;
    end

    tgap_cfg #(.TURN_W(TURN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_turn),
        .turn_q    (turn_q)
    );

    tgap_history #(.BANK_W(BANK_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .bank       (req_bank),
        .kind       (next_kind),
        .prev_valid (prev_valid),
        .prev_bank  (prev_bank),
        .prev_kind  (prev_kind)
    );

    tgap_rule #(
        .BANK_W   (BANK_W),
        .TURN_W   (TURN_W),
        .FIX_NEAR (FIX_NEAR),
        .FIX_FAR  (FIX_FAR)
    ) u_rule (
        .prev_valid (prev_valid),
        .prev_bank  (prev_bank),
        .prev_kind  (prev_kind),
        .next_bank  (req_bank),
        .next_kind  (next_kind),
        .turn       (turn_q),
        .muxed      (cfg_muxed),
        .ext_en     (cfg_ext_en),
        .acc_mode   (cfg_acc_mode),
        .gap        (gap_now)
    );

    tgap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .gap       (gap_now),
        .start     (xfer_start),
        .ready     (req_ready)
    );

    AST_READ_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!prev_valid || prev_kind == TK_ASYNC_RD || prev_kind == TK_SYNC_RD)
         && !$past(xfer_start)) |-> req_ready); // R2
    AST_SYNC_WR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && prev_kind == TK_SYNC_WR)
        |-> (gap_now == GAP_W'(FIX_NEAR) || gap_now == GAP_W'(FIX_FAR))); // R5

endmodule

// File: tb/turnaround_gap_seq_bench.sv
`timescale 1ns/1ps
module turnaround_gap_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_turn = 4'd0;
    logic       cfg_muxed = 1'b0;
    logic       cfg_ext_en = 1'b0;
    logic [1:0] cfg_acc_mode = 2'd0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = 2'd0;
    logic       req_write = 1'b0;
    logic       req_sync = 1'b0;
    logic       xfer_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the turn register and the last launched transaction.
    int   m_turn = 15;
    bit   m_pv = 1'b0;
    bit [1:0] m_pb = 2'd0;
    bit   m_pw = 1'b0;
    bit   m_ps = 1'b0;

    always #4 clk = ~clk;

    turnaround_gap_seq u_turnaround_gap_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_turn     (cfg_turn),
        .cfg_muxed    (cfg_muxed),
        .cfg_ext_en   (cfg_ext_en),
        .cfg_acc_mode (cfg_acc_mode),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_write    (req_write),
        .req_sync     (req_sync),
        .xfer_start   (xfer_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected gap from the requirements.
    function automatic int exp_gap(input bit [1:0] nb, input bit nw, input bit ns);
        if (!m_pv || !m_pw) return 0;                                       // R2
        if (!m_ps) begin
            if (nw && !ns && nb == m_pb && !cfg_muxed && !(cfg_ext_en && cfg_acc_mode == 2'd3))
                return 0;                                                   // R4
            return m_turn + 1;                                              // R3
        end
        if (!ns) return 2;                                                  // R5
        if (nw && nb == m_pb) return 2;                                     // R6
        return 3;                                                           // R6 / R7
    endfunction

    function automatic string tag_of(input bit [1:0] nb, input bit nw, input bit ns);
        if (!m_pv || !m_pw) return "R2";
        if (!m_ps) return (nw && !ns && nb == m_pb) ? "R4" : "R3";
        if (!ns) return "R5";
        if (nw) return "R6";
        return "R7";
    endfunction

    task automatic write_turn(input int v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_turn = 4'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_turn = v;
    endtask

    // One request: present, count cycles with ready low, check, retire.
    task automatic xfer(input bit [1:0] nb, input bit nw, input bit ns,
                        input int mid_at, input int mid_val, input string force_tag);
        int waited = 0;
        int exp;
        string tag;
        exp = exp_gap(nb, nw, ns);
        tag = (force_tag != "") ? force_tag : tag_of(nb, nw, ns);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank = nb;
        req_write = nw;
        req_sync = ns;
        #1;
        while (!req_ready && waited < 40) begin
            @(negedge clk);
            waited++;
            if (mid_at > 0 && waited == mid_at) begin
                cfg_wr = 1'b1;
                cfg_turn = 4'(mid_val);
            end else begin
                cfg_wr = 1'b0;
            end
            #1;
        end
        cfg_wr = 1'b0;
        if (mid_at > 0) m_turn = mid_val;
        check(waited == exp, {tag, " R8 gap length"}, waited, exp);
        check(xfer_start == 1'b1, "R8 start strobe on accept", int'(xfer_start), 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        m_pv = 1'b1;
        m_pb = nb;
        m_pw = nw;
        m_ps = ns;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        check(xfer_start == 1'b0, "R8 no start while idle", int'(xfer_start), 0);

        // Directed corner cases.
        xfer(2'd0, 1'b1, 1'b0, 0, 0, "R2");      // first ever: no gap
        xfer(2'd0, 1'b0, 1'b0, 0, 0, "R1");      // reset turn 15 -> 16
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // after read: 0
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // async wr same bank: 0
        cfg_muxed = 1'b1;
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // muxed: 16
        cfg_muxed = 1'b0;
        cfg_ext_en = 1'b1;
        cfg_acc_mode = 2'd3;
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // mode D: 16
        cfg_acc_mode = 2'd1;
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // other mode: 0
        cfg_ext_en = 1'b0;
        write_turn(3);
        xfer(2'd2, 1'b1, 1'b0, 0, 0, "");        // different bank: 4
        xfer(2'd2, 1'b1, 1'b1, 0, 0, "");        // async wr -> sync wr: 4
        xfer(2'd2, 1'b1, 1'b1, 0, 0, "");        // sync wr same bank: 2
        xfer(2'd3, 1'b1, 1'b1, 0, 0, "");        // sync wr other bank: 3
        xfer(2'd0, 1'b0, 1'b0, 0, 0, "");        // sync wr -> async rd: 2
        xfer(2'd0, 1'b1, 1'b1, 0, 0, "");        // after read: 0
        xfer(2'd1, 1'b0, 1'b1, 0, 0, "");        // sync wr -> sync rd: 3
        xfer(2'd1, 1'b1, 1'b1, 0, 0, "");
        xfer(2'd1, 1'b1, 1'b0, 0, 0, "");        // sync wr -> async wr: 2
        write_turn(15);
        xfer(2'd0, 1'b0, 1'b0, 3, 0, "R9");      // turn rewritten mid-gap: still 16
        xfer(2'd0, 1'b1, 1'b0, 0, 0, "");
        xfer(2'd3, 1'b0, 1'b1, 0, 0, "R1");      // new turn 0 in use: 1
        @(negedge clk);
        #1;
        check(xfer_start == 1'b0, "R8 no start without request", int'(xfer_start), 0);

        // Random stream.
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(7) == 0) begin
                cfg_muxed = 1'($urandom_range(1));
                cfg_ext_en = 1'($urandom_range(1));
                cfg_acc_mode = 2'($urandom_range(3));
            end
            if ($urandom_range(9) == 0) write_turn(int'($urandom_range(15)));
            if ($urandom_range(3) == 0) @(negedge clk);
            xfer(2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)), 0, 0, "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule